// File: doc/BRIEF.md
# Sticky-Latch Interrupt Aggregator

This block gathers 24 peripheral interrupt lines into one interrupt request for a host processor. Each line first passes through a two-flop synchroniser. It is then captured into a pending ("sticky") bit, either on each rising edge or on every cycle it is high, as the per-source trigger configuration selects. Software masks sources through an enable register. That register can be written whole, or bits can be set and cleared one at a time through separate write-one ports.

An identity word reports the sources that are both pending and enabled. Bit position equals source number, so software may service the highest set bit first. The host interrupt line is the registered OR of that word.

Access uses a simple 32-bit port with word addressing and a combinational read. Bits 31 down to 24 of every register read as zero, and so do unmapped locations.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: After reset the pending, enable and both trigger registers read zero and `irq_out` is low.
- R2: Unmapped word addresses read zero, and bits 31:24 of every register read zero, even after all-ones writes.
- R3: Writing the pending word (word address 4) clears each bit written as 1; bits written as 0 keep their value.
- R4: A write to enable-set (word 8) sets each enable bit written as 1, and a write to enable-clear (word 7) clears each one written as 1; zero bits leave the enable unchanged.
- R5: A direct write to the enable word (word 6) replaces its whole contents; writing 0 masks every source.
- R6: A source whose bit is 0 in both trigger words (word 1 and word 2) is level-captured: its pending bit is set on every cycle the synchronised input is high, so a clear does not stick while the input stays high.
- R7: A source whose bit is 1 in either trigger word is edge-captured: one rising edge sets the pending bit once, and after a clear the bit stays clear while the input is held high.
- R8: The identity word (word 14) reads pending AND enable, bit for bit.
- R9: `irq_out` is the OR of the identity bits, delayed by one register.
- R10: When capture sets a pending bit in the same cycle that software clears it, the bit ends set.
- R11: An input change reaches the pending bit on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 24 | Raw peripheral interrupt lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
The bench sweeps every source through both capture modes, using each trigger word in turn. It checks the exact cycle where the pending bit first appears. A missing or extra synchroniser stage would show the bit one edge too early or too late. It clears a level source while the input is still high and expects the bit back. A design that let the clear win, or that treated a level source as edge-captured, would lose that bit. It also clears an edge source while the input is held and expects the bit to stay clear, which catches a design that re-arms on level. Finally, it lines up a software clear with a capture edge in the same cycle, and it checks the masking of identity and `irq_out` after a whole-word enable write.

// File: rtl/sticky_irq_ctrl.sv
module sticky_irq_ctrl #(
  parameter int N_SRC = 24,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq_out
);
  localparam logic [AW-1:0] A_TRG0 = AW'(1);
  localparam logic [AW-1:0] A_TRG1 = AW'(2);
  localparam logic [AW-1:0] A_PEND = AW'(4);
  localparam logic [AW-1:0] A_EN   = AW'(6);
  localparam logic [AW-1:0] A_ENC  = AW'(7);
  localparam logic [AW-1:0] A_ENS  = AW'(8);
  localparam logic [AW-1:0] A_ID   = AW'(14);
  localparam int PAD = DW - N_SRC;

  logic [N_SRC-1:0] sy1, sy2, sy3;
  logic [N_SRC-1:0] trg0, trg1, pend, en;
  logic [N_SRC-1:0] edge_mode, rise, hw_set, w1c, ident;
  logic [N_SRC-1:0] wd;
  logic [N_SRC-1:0] rsel;

  assign wd        = wdata[N_SRC-1:0];
  assign edge_mode = trg0 | trg1;
  assign rise      = sy2 & ~sy3;
  assign hw_set    = (edge_mode & rise) | (~edge_mode & sy2);
  assign w1c       = (wr_en && addr == A_PEND) ? wd : '0;
  assign ident     = pend & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= irq_in; sy2 <= sy1; sy3 <= sy2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trg0 <= '0; trg1 <= '0;
    end else if (wr_en) begin
      if (addr == A_TRG0) trg0 <= wd;
      if (addr == A_TRG1) trg1 <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~w1c) | hw_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en <= '0;
    else if (wr_en) begin
      case (addr)
        A_EN:    en <= wd;
        A_ENS:   en <= en | wd;
        A_ENC:   en <= en & ~wd;
        default: en <= en;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |ident;
  end

  always_comb begin
    case (addr)
      A_TRG0:  rsel = trg0;
      A_TRG1:  rsel = trg1;
      A_PEND:  rsel = pend;
      A_EN:    rsel = en;
      A_ID:    rsel = ident;
      default: rsel = '0;
    endcase
  end
  assign rdata = {{PAD{1'b0}}, rsel};

  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((pend & $past(hw_set)) == $past(hw_set)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PEND) |=> ((pend & $past(wd & ~hw_set)) == '0));

  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_EN || addr == A_ENS || addr == A_ENC)) |=> $stable(en));

  p_irq_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(pend & en))));

  p_edge_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & edge_mode & ~$past(pend))) |-> (|$past(sy2 & ~sy3)) || $past(wr_en));

  always_comb begin
    if (rst_n) p_hi_zero_r2: assert (rdata[DW-1:N_SRC] == '0);
  end
endmodule

// File: tb/sticky_irq_ctrl_test.sv
module sticky_irq_ctrl_test;
  localparam int N = 24;
  localparam logic [31:0] M = 32'h00FF_FFFF;
  logic clk = 0, rst_n = 0, wr_en = 0, irq_out;
  logic [N-1:0] irq_in = '0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  sticky_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v, b;
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    foreach (v[i]) ;
    rreg(4'd1, v); chk("R1 trig0", v, 0);
    rreg(4'd2, v); chk("R1 trig1", v, 0);
    rreg(4'd4, v); chk("R1 pend", v, 0);
    rreg(4'd6, v); chk("R1 en", v, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);
    // R2 unmapped and upper bits
    for (int a = 0; a < 16; a++) begin
      if (!(a inside {1, 2, 4, 6, 14})) begin
        rreg(4'(a), v); chk($sformatf("R2 addr %0d", a), v, 0);
      end
    end
    wreg(4'd1, 32'hFFFF_FFFF); rreg(4'd1, v); chk("R2 trig0 width", v, M);
    wreg(4'd1, 0);
    // R4 set/clear
    wreg(4'd8, 32'h5); rreg(4'd6, v); chk("R4 set", v, 32'h5);
    wreg(4'd7, 32'h1); rreg(4'd6, v); chk("R4 clr", v, 32'h4);
    wreg(4'd8, 0);     rreg(4'd6, v); chk("R4 set zero", v, 32'h4);
    wreg(4'd7, 0);     rreg(4'd6, v); chk("R4 clr zero", v, 32'h4);
    // R5 direct write
    wreg(4'd6, 32'hFFFF_FFFF); rreg(4'd6, v); chk("R5 all", v, M);
    wreg(4'd6, 0); rreg(4'd6, v); chk("R5 zero", v, 0);

    // level sweep, enabled
    for (int i = 0; i < N; i++) begin
      b = 32'h1 << i;
      wreg(4'd8, b);
      @(negedge clk); irq_in[i] = 1'b1;
      cyc(2); rreg(4'd4, v); chk($sformatf("R11 early src %0d", i), v, 0);
      cyc(1); rreg(4'd4, v); chk($sformatf("R11 third edge src %0d", i), v, b);
      rreg(4'd14, v); chk($sformatf("R8 ident src %0d", i), v, b);
      chk("R9 not yet", {31'b0, irq_out}, 0);
      cyc(1); chk("R9 irq_out", {31'b0, irq_out}, 1);
      wreg(4'd4, 0); rreg(4'd4, v); chk("R3 zero write", v, b);
      wreg(4'd4, b); rreg(4'd4, v); chk($sformatf("R6 level resets src %0d", i), v, b);
      irq_in[i] = 1'b0;
      cyc(3);
      wreg(4'd4, 32'hFFFF_FFFF); rreg(4'd4, v); chk($sformatf("R3 clear src %0d", i), v, 0);
      cyc(1); chk("R9 irq_out low", {31'b0, irq_out}, 0);
      wreg(4'd7, b);
    end

    // edge sweep, masked
    wreg(4'd6, 0);
    for (int i = 0; i < N; i++) begin
      b = 32'h1 << i;
      wreg((i % 2 == 0) ? 4'd1 : 4'd2, b);
      @(negedge clk); irq_in[i] = 1'b1;
      cyc(3); rreg(4'd4, v); chk($sformatf("R7 edge set src %0d", i), v, b);
      rreg(4'd14, v); chk("R8 masked ident", v, 0);
      cyc(1); chk("R9 masked irq", {31'b0, irq_out}, 0);
      wreg(4'd4, b); cyc(3); rreg(4'd4, v); chk($sformatf("R7 held stays clear src %0d", i), v, 0);
      irq_in[i] = 1'b0; cyc(3);
      wreg((i % 2 == 0) ? 4'd1 : 4'd2, 0);
    end

    // R10: software clear lands on the capture edge
    wreg(4'd2, 32'h80);
    @(negedge clk); irq_in[7] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1; addr = 4'd4; wdata = 32'hFFFF_FFFF;
    @(negedge clk); wr_en = 0; wdata = 0;
    rreg(4'd4, v); chk("R10 set wins", v, 32'h80);
    wreg(4'd6, 32'hFFFF_FFFF); rreg(4'd14, v); chk("R8 ident enabled", v, 32'h80);
    cyc(1); chk("R9 irq_out enabled", {31'b0, irq_out}, 1);
    irq_in[7] = 1'b0;
    finish_up();
  end
endmodule